// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps wall-clock time and a simple calendar in eight byte-wide registers. Seven of them hold packed BCD counters: seconds, minutes, hours, weekday, day of month, month and two-digit year. The eighth holds control bits. A one-cycle strobe on `tick_i`, raised once per second by the surrounding logic, advances the counters. Carries ripple from seconds up to the year within that single clock edge.

Software reaches the bank over a plain byte bus. The address selects a register, a write strobe qualifies the write data, and read data is a combinational function of the address. The running counters sit behind a second, user-visible copy of the time fields.

- Setting the load bit in control turns that copy into a holding area. Software can write any field there while the counters keep running. Clearing the bit copies the whole area into the counters in one edge.
- Setting the freeze bit keeps the copy still, so several bytes can be read as one snapshot. The counters keep advancing during the freeze.

Three flags are stored in otherwise unused high bits of the time registers: a counting stop, a start-up flag and a test flag. A spare bit in control holds a calibration sign.

Top module: `tod_bcd_bank`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00, weekday, date and month read 0x01, year reads 0x00, and control and all flag bits read 0.
- R2: Offset 0 is control, with the load bit in bit 7, the freeze bit in bit 6, the sign bit in bit 5 and zeros below. Offsets 1 to 7 are seconds, minutes, hours, weekday, date, month and year, each holding the tens digit in bits 7:4 and the units digit in bits 3:0.
- R3: Each clock edge that sees `tick_i` high, with the stop flag clear, advances seconds by one decimal step (09 to 10, for example). The new value can be read in the following cycle.
- R4: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and advance both weekday and date.
- R5: Weekday wraps from 7 to 1. Date wraps from 31 to 01 and carries into month. Month wraps from 12 to 01 and carries into year. Year wraps from 99 to 00.
- R6: Bit 7 of offset 1 is the stop flag. It can be written whatever the load bit is. While it is set, ticks leave every counter unchanged.
- R7: While the load bit is set, writes to offsets 1 to 7 go into the holding copy and read back from it. Ticks do not alter the holding copy.
- R8: A control write that clears a set load bit copies the holding copy into the counters on that edge. A tick on the same edge is dropped.
- R9: While the load bit is clear, writes to offsets 1 to 7 leave the BCD fields unchanged. Only the flag bits are taken.
- R10: While the freeze bit is set, reads of offsets 1 to 7 return the values captured when it was set, and the counters keep counting. After the bit is cleared, reads show the current counters, including ticks that arrived during the freeze.
- R11: Bit 7 of offset 3 (start-up flag), bit 6 of offset 4 (test flag) and bit 5 of offset 0 (sign) are plain read/write state that never alter a BCD field.
- R12: Field masks are 0x7F for seconds and minutes, 0x3F for hours, 0x07 for weekday, 0x3F for date, 0x1F for month and 0xFF for year. Bits outside a mask that are not a flag read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Register offset |
| wr_data_i | input | DATA_W | Bus write data |
| rd_data_o | output | DATA_W | Bus read data, combinational from addr_i |

## Verification
The hardest state to reach from the ports is a full carry from seconds all the way into the year. Counting there with ticks alone would take tens of millions of cycles. The bench instead uses the load path to place each table row just short of the boundary, releases it, and issues a few ticks. A second condition that is hard to hit is a tick arriving on the exact edge of the release. The bench's write task can raise `tick_i` together with the control write that clears the load bit, which forces that case.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int NUM_FIELDS = 7;

   typedef enum logic [2:0] {
      OFS_CTRL  = 3'd0,
      OFS_SEC   = 3'd1,
      OFS_MIN   = 3'd2,
      OFS_HOUR  = 3'd3,
      OFS_WDAY  = 3'd4,
      OFS_DATE  = 3'd5,
      OFS_MONTH = 3'd6,
      OFS_YEAR  = 3'd7
   } tod_ofs_e;

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic int field_lo(input int k);
      return (k == 4 || k == 5 || k == 6) ? 1 : 0;
   endfunction

   function automatic int field_hi(input int k, input int date_last, input int year_last);
      case (k)
         1, 2:    return 59;
         3:       return 23;
         4:       return 7;
         5:       return date_last;
         6:       return 12;
         default: return year_last;
      endcase
   endfunction

   function automatic logic [7:0] field_mask(input int k);
      case (k)
         1, 2:    return 8'h7F;
         3, 5:    return 8'h3F;
         4:       return 8'h07;
         6:       return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   // index of the carry that advances field k (0 = gated tick)
   function automatic int carry_src(input int k);
      case (k)
         1:       return 0;
         2:       return 1;
         3:       return 2;
         4, 5:    return 3;
         6:       return 5;
         default: return 6;
      endcase
   endfunction
endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
   parameter logic [7:0] LO_BCD = 8'h00,
   parameter logic [7:0] HI_BCD = 8'h59,
   parameter logic [7:0] MASK   = 8'h7F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc_i,
   input  logic       load_i,
   input  logic [7:0] load_val_i,
   output logic [7:0] val_o,
   output logic       wrap_o
);
   import tod_pkg::*;

   generate
      if (HI_BCD <= LO_BCD) begin : g_bad_range
         $error("tod_bcd_field: HI_BCD must exceed LO_BCD");
      end
   endgenerate

   logic [7:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= LO_BCD;
      else if (load_i) val_q <= load_val_i & MASK;
      else if (inc_i)  val_q <= (val_q == HI_BCD) ? LO_BCD : (bcd_step(val_q) & MASK);
   end

   assign val_o  = val_q;
   assign wrap_o = inc_i && !load_i && (val_q == HI_BCD);

   // R4
   wrap_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && val_o == HI_BCD) |=> (val_o == LO_BCD));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(val_o));
endmodule

// File: rtl/tod_ctrl_reg.sv
module tod_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_hit_i,
   input  logic sec_hit_i,
   input  logic hour_hit_i,
   input  logic wday_hit_i,
   input  logic d7_i,
   input  logic d6_i,
   input  logic d5_i,
   output logic load_o,
   output logic freeze_o,
   output logic sign_o,
   output logic stop_o,
   output logic kick_o,
   output logic ftest_o,
   output logic release_o
);
   logic load_q, freeze_q, sign_q, stop_q, kick_q, ftest_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q   <= 1'b0;
         freeze_q <= 1'b0;
         sign_q   <= 1'b0;
         stop_q   <= 1'b0;
         kick_q   <= 1'b0;
         ftest_q  <= 1'b0;
      end else begin
         if (ctrl_hit_i) begin
            load_q   <= d7_i;
            freeze_q <= d6_i;
            sign_q   <= d5_i;
         end
         if (sec_hit_i)  stop_q  <= d7_i;
         if (hour_hit_i) kick_q  <= d7_i;
         if (wday_hit_i) ftest_q <= d6_i;
      end
   end

   assign load_o    = load_q;
   assign freeze_o  = freeze_q;
   assign sign_o    = sign_q;
   assign stop_o    = stop_q;
   assign kick_o    = kick_q;
   assign ftest_o   = ftest_q;
   assign release_o = ctrl_hit_i && load_q && !d7_i;

   // R8
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |=> !load_o);

   // R11
   kick_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hour_hit_i |=> $stable(kick_o));
endmodule

// File: rtl/tod_bcd_bank.sv
module tod_bcd_bank #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int DATE_LAST = 31,
   parameter int YEAR_LAST = 99
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);
   import tod_pkg::*;

   localparam int NF = NUM_FIELDS;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("tod_bcd_bank: packed BCD needs DATA_W of 8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("tod_bcd_bank: ADDR_W must cover eight registers");
      end
      if (DATE_LAST < 28 || DATE_LAST > 31) begin : g_bad_date
         $error("tod_bcd_bank: DATE_LAST out of range");
      end
      if (YEAR_LAST < 1 || YEAR_LAST > 99) begin : g_bad_year
         $error("tod_bcd_bank: YEAR_LAST out of range");
      end
   endgenerate

   logic load_q, freeze_q, sign_q, stop_q, kick_q, ftest_q, release_w;
   logic hit [0:NF];
   logic carry [0:NF];
   logic [7:0] run_w  [1:NF];
   logic [7:0] hold_w [1:NF];
   logic [7:0] view_w [1:NF];

   genvar h;
   generate
      for (h = 0; h <= NF; h++) begin : g_hit
         assign hit[h] = wr_en_i && (addr_i == ADDR_W'(h));
      end
   endgenerate

   tod_ctrl_reg u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_hit_i (hit[OFS_CTRL]),
      .sec_hit_i  (hit[OFS_SEC]),
      .hour_hit_i (hit[OFS_HOUR]),
      .wday_hit_i (hit[OFS_WDAY]),
      .d7_i       (wr_data_i[7]),
      .d6_i       (wr_data_i[6]),
      .d5_i       (wr_data_i[5]),
      .load_o     (load_q),
      .freeze_o   (freeze_q),
      .sign_o     (sign_q),
      .stop_o     (stop_q),
      .kick_o     (kick_q),
      .ftest_o    (ftest_q),
      .release_o  (release_w)
   );

   assign carry[0] = tick_i && !stop_q && !release_w;

   genvar k;
   generate
      for (k = 1; k <= NF; k++) begin : g_field
         localparam logic [7:0] F_MASK = field_mask(k);
         logic [7:0] hold_q;

         tod_bcd_field #(
            .LO_BCD (to_bcd(field_lo(k))),
            .HI_BCD (to_bcd(field_hi(k, DATE_LAST, YEAR_LAST))),
            .MASK   (F_MASK)
         ) u_fld (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (carry[carry_src(k)]),
            .load_i     (release_w),
            .load_val_i (hold_q),
            .val_o      (run_w[k]),
            .wrap_o     (carry[k])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 hold_q <= to_bcd(field_lo(k));
            else if (load_q && hit[k])  hold_q <= wr_data_i & F_MASK;
            else if (!load_q && !freeze_q) hold_q <= run_w[k];
         end

         assign hold_w[k] = hold_q;
         assign view_w[k] = (load_q || freeze_q) ? hold_q : run_w[k];
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      if (addr_i == ADDR_W'(OFS_CTRL)) begin
         rd_data_o = {load_q, freeze_q, sign_q, 5'b0};
      end else if (addr_i <= ADDR_W'(NF)) begin
         rd_data_o = view_w[addr_i[2:0]];
         if (addr_i == ADDR_W'(OFS_SEC))  rd_data_o[7] = stop_q;
         if (addr_i == ADDR_W'(OFS_HOUR)) rd_data_o[7] = kick_q;
         if (addr_i == ADDR_W'(OFS_WDAY)) rd_data_o[6] = ftest_q;
      end
   end

   // R6
   stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !release_w) |=> $stable(run_w[1]));

   // R10
   snapshot_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_q && !load_q) |=> ($stable(hold_w[1]) && $stable(hold_w[7])));

   // R8
   release_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_w |=> (run_w[1] == $past(hold_w[1]) && run_w[7] == $past(hold_w[7])));

   // R7
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_q && !hit[OFS_SEC]) |=> $stable(hold_w[1]));

   // R5
   year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry[NF] |=> (run_w[NF] == 8'h00));
endmodule

// File: tb/tod_bcd_bank_tb.sv
module tod_bcd_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NROWS = 10;

   // {ticks, start YY_MM_DD_WD_HH_MI_SS, expected YY_MM_DD_WD_HH_MI_SS}
   localparam logic [119:0] VEC [NROWS] = '{
      {8'd5,  56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_05},
      {8'd1,  56'h00_01_01_01_00_00_09, 56'h00_01_01_01_00_00_10},
      {8'd1,  56'h00_01_01_01_00_12_59, 56'h00_01_01_01_00_13_00},
      {8'd1,  56'h00_01_01_01_09_59_59, 56'h00_01_01_01_10_00_00},
      {8'd1,  56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00},
      {8'd1,  56'h42_06_15_03_23_59_59, 56'h42_06_16_04_00_00_00},
      {8'd1,  56'h07_05_31_02_23_59_59, 56'h07_06_01_03_00_00_00},
      {8'd3,  56'h00_01_01_01_00_07_58, 56'h00_01_01_01_00_08_01},
      {8'd1,  56'h19_12_31_05_23_59_59, 56'h20_01_01_06_00_00_00},
      {8'd62, 56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_01_02}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tod_bcd_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wr_data_i (wr_data),
      .rd_data_o (rd_data)
   );

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic tk = 1'b0);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1; tick = tk;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s offset %0d actual=%02h expected=%02h", req, a, rd_data, exp);
      end
   endtask

   task automatic set_time(input logic [55:0] t);
      wr(3'd0, 8'h80);
      for (int k = 1; k <= 7; k++) wr(3'(k), t[8*(k-1) +: 8]);
      wr(3'd0, 8'h00);
   endtask

   task automatic chk_reset(input string req);
      chk(req, 3'd0, 8'h00);
      chk(req, 3'd1, 8'h00);
      chk(req, 3'd2, 8'h00);
      chk(req, 3'd3, 8'h00);
      chk(req, 3'd4, 8'h01);
      chk(req, 3'd5, 8'h01);
      chk(req, 3'd6, 8'h01);
      chk(req, 3'd7, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 R2: reset values through the register map
      chk_reset("R1 R2 reset");

      // R3: plain counting
      ticks(3);
      chk("R3 count", 3'd1, 8'h03);

      // R4 R5: table of preset times and carries
      for (int i = 0; i < NROWS; i++) begin
         set_time(VEC[i][111:56]);
         ticks(int'(VEC[i][119:112]));
         for (int k = 1; k <= 7; k++)
            chk($sformatf("R4 R5 row %0d", i), 3'(k), VEC[i][8*(k-1) +: 8]);
      end

      // R6: stop flag
      set_time(56'h00_01_01_01_00_00_00);
      wr(3'd1, 8'h80);
      chk("R6 stop set", 3'd1, 8'h80);
      ticks(4);
      chk("R6 stopped", 3'd1, 8'h80);
      wr(3'd1, 8'h00);
      ticks(2);
      chk("R6 restarted", 3'd1, 8'h02);

      // R9: field writes without load bit
      wr(3'd1, 8'h45);
      chk("R9 sec ignored", 3'd1, 8'h02);
      wr(3'd7, 8'h55);
      chk("R9 year ignored", 3'd7, 8'h00);

      // R7 R8: holding copy and release
      wr(3'd0, 8'h80);
      wr(3'd1, 8'h20);
      ticks(3);
      chk("R7 hold kept", 3'd1, 8'h20);
      chk("R2 ctrl load bit", 3'd0, 8'h80);
      wr(3'd0, 8'h00, 1'b1);
      chk("R8 release drops tick", 3'd1, 8'h20);
      ticks(1);
      chk("R8 counts after release", 3'd1, 8'h21);

      // R10: freeze
      wr(3'd0, 8'h40);
      ticks(5);
      chk("R10 frozen", 3'd1, 8'h21);
      chk("R2 ctrl freeze bit", 3'd0, 8'h40);
      wr(3'd0, 8'h00);
      chk("R10 resync", 3'd1, 8'h26);

      // R11: embedded flags
      wr(3'd3, 8'h80);
      chk("R11 kick", 3'd3, 8'h80);
      wr(3'd4, 8'h40);
      chk("R11 ftest", 3'd4, 8'h41);
      wr(3'd0, 8'h20);
      chk("R11 sign", 3'd0, 8'h20);
      wr(3'd3, 8'h00);
      wr(3'd4, 8'h00);
      wr(3'd0, 8'h00);
      chk("R11 hour intact", 3'd3, 8'h00);
      chk("R11 wday intact", 3'd4, 8'h01);

      // R12: field masks
      wr(3'd0, 8'h80);
      for (int k = 1; k <= 7; k++) wr(3'(k), 8'hFF);
      chk("R12 sec", 3'd1, 8'hFF);
      chk("R12 min", 3'd2, 8'h7F);
      chk("R12 hour", 3'd3, 8'hBF);
      chk("R12 wday", 3'd4, 8'h47);
      chk("R12 date", 3'd5, 8'h3F);
      chk("R12 month", 3'd6, 8'h1F);
      chk("R12 year", 3'd7, 8'hFF);

      // R1: reset in the middle of operation
      set_time(56'h33_07_14_02_11_22_44);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk_reset("R1 mid-run reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule